// File: doc/BRIEF.md
# Page-Break Bus Cycle Accountant

This block watches the memory accesses that a fast processor core issues and works out what each instruction costs in bus cycles. Each access has a fixed base cost that depends on its type. A data access (read or write) costs one more cycle when its upper address byte differs from the upper byte of the data access just before it in the same instruction. The upper address byte selects a 256-byte page. Opcode fetches have their own base cost and take no part in the page comparison.

When an instruction-boundary marker arrives, the block closes the current instruction. The accumulated total then appears on the output, together with a one-cycle valid pulse. A running, saturating count of page breaks is also kept. The block lets a designer compare different orderings of the same transfers. For example, a stack-top swap can do its two reads and two writes in several orders, and the block gives 7, 8, 9 or 10 cycles depending on that order and on whether the stack word straddles a page.

Control is a two-state machine:
- `PS_FRESH`: no data page is held for the current instruction.
- `PS_TRACK`: the page of the last data access is held.

Transitions:
- `fresh_to_track`: a data access arrives with no boundary marker in the same cycle.
- `track_to_fresh`: a boundary marker arrives.
- `fresh_hold`: stay in `PS_FRESH` on anything else while fresh.
- `track_hold`: stay in `PS_TRACK` on anything else while tracking.

Top module: `pbk_acct`

## Requirements
- R1: While reset is asserted, `insn_valid` is 0, `insn_cycles` is 0 and `brk_count` is 0.
- R2: Access type encoding on `acc_kind`: 2'b00 = fetch, costing FETCH_CYC (default 3); 2'b01 = read and 2'b10 = write, each costing DATA_CYC (default 1); 2'b11 = no-op, costing 0 and leaving the page comparison untouched.
- R3: A valid read or write whose address bits [15:8] differ from those of the previous read or write of the same instruction adds exactly 1 cycle to the instruction total and increments `brk_count` by 1.
- R4: Fetches neither count as a page break nor replace the remembered page.
- R5: The first read or write after a boundary marker is never a page break.
- R6: When `insn_end` is sampled high, the instruction total appears on `insn_cycles` with `insn_valid` high in the next cycle only. An access sampled in the same cycle as `insn_end` belongs to the instruction being closed. A boundary with no accesses reports 0. Boundaries on consecutive cycles give consecutive pulses.
- R7: `brk_count` never decreases and saturates at 2^BRK_W-1 (default 255).
- R8: A cycle with `acc_valid` low adds no cost and changes neither the remembered page nor `brk_count`.
- R9: A stack-top swap (fetch, then two reads and two writes of SP and SP+1) reports the following totals:
  - 7 when both bytes are in one page.
  - 9 for the order low read, high read, high write, low write across a page boundary.
  - 10 for the order high read, low read, high write, low write across a page boundary.
  - 8 for the order low read, low write, high read, high write across a page boundary.
- R10: The instruction total saturates at 2^TOT_W-1 (default 255) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is present this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_kind | input | 2 | Access type: 00 fetch, 01 read, 10 write, 11 no-op |
| insn_end | input | 1 | Closes the current instruction |
| insn_cycles | output | TOT_W | Total of the last closed instruction |
| insn_valid | output | 1 | One-cycle pulse marking a new total |
| brk_count | output | BRK_W | Saturating running count of page breaks |

## Verification
The instruction total is registered once. It is due exactly one clock after the edge that samples `insn_end`. Inputs change on the falling edge, so the monitor looks at `insn_valid` on the following falling edge and matches each pulse against the next queued expectation. A pulse with nothing queued, or an item left in the queue at the end, counts as a failure.

`brk_count` also updates on the edge that samples the access. It is compared on the falling edge after the last access of a sequence, once the inputs have gone idle.

// File: rtl/pbk_pkg.sv
package pbk_pkg;

    typedef enum logic [1:0] {
        AK_FETCH = 2'b00,
        AK_READ  = 2'b01,
        AK_WRITE = 2'b10,
        AK_NONE  = 2'b11
    } acc_kind_e;

    typedef enum logic {
        PS_FRESH = 1'b0,
        PS_TRACK = 1'b1
    } pbk_state_e;

endpackage

// File: rtl/pbk_cost.sv
module pbk_cost #(
    parameter int CW        = 8,
    parameter int FETCH_CYC = 3,
    parameter int DATA_CYC  = 1
) (
    input  logic [1:0]    kind,
    output logic [CW-1:0] cost,
    output logic          is_data
);
    import pbk_pkg::*;

    always_comb begin
        cost    = '0;
        is_data = 1'b0;
        unique case (acc_kind_e'(kind))
            AK_FETCH: cost = CW'(FETCH_CYC);
            AK_READ,
            AK_WRITE: begin
                cost    = CW'(DATA_CYC);
                is_data = 1'b1;
            end
            AK_NONE:  cost = '0;
            default:  cost = '0;
        endcase
    end
endmodule

// File: rtl/pbk_satcnt.sv
module pbk_satcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (inc && (cnt != CNT_MAX))
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pbk_acct.sv
module pbk_acct #(
    parameter int ADDR_W     = 16,
    parameter int PAGE_SHIFT = 8,
    parameter int TOT_W      = 8,
    parameter int BRK_W      = 8,
    parameter int FETCH_CYC  = 3,
    parameter int DATA_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_kind,
    input  logic              insn_end,
    output logic [TOT_W-1:0]  insn_cycles,
    output logic              insn_valid,
    output logic [BRK_W-1:0]  brk_count
);
    import pbk_pkg::*;

    localparam int               PAGE_W  = ADDR_W - PAGE_SHIFT;
    localparam int               SUM_W   = TOT_W + 2;
    localparam logic [TOT_W-1:0] TOT_MAX = '1;

    pbk_state_e        st, st_nxt;
    logic [PAGE_W-1:0] last_page, cur_page;
    logic [TOT_W-1:0]  run_sum, base_cost;
    logic              is_data, brk_hit;
    logic [SUM_W-1:0]  sum_wide;
    logic [TOT_W-1:0]  sum_sat;

    pbk_cost #(
        .CW       (TOT_W),
        .FETCH_CYC(FETCH_CYC),
        .DATA_CYC (DATA_CYC)
    ) u_cost (
        .kind   (acc_kind),
        .cost   (base_cost),
        .is_data(is_data)
    );

    assign cur_page = acc_addr[ADDR_W-1:PAGE_SHIFT];
    assign brk_hit  = acc_valid && is_data && (st == PS_TRACK) && (cur_page != last_page);

    always_comb begin
        sum_wide = SUM_W'(run_sum)
                 + (acc_valid ? SUM_W'(base_cost) : SUM_W'(0))
                 + SUM_W'(brk_hit);
        sum_sat  = (sum_wide > SUM_W'(TOT_MAX)) ? TOT_MAX : sum_wide[TOT_W-1:0];
    end

    pbk_satcnt #(.W(BRK_W)) u_brk (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (brk_hit),
        .cnt  (brk_count)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= PS_FRESH;
        else
            st <= st_nxt;
    end

    // transitions: fresh_to_track, track_to_fresh, fresh_hold, track_hold
    always_comb begin
        st_nxt = st;
        unique case (st)
            PS_FRESH: if (!insn_end && acc_valid && is_data) st_nxt = PS_TRACK;
            PS_TRACK: if (insn_end)                          st_nxt = PS_FRESH;
            default:                                         st_nxt = PS_FRESH;
        endcase
    end

    // outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_page   <= '0;
            run_sum     <= '0;
            insn_cycles <= '0;
            insn_valid  <= 1'b0;
        end else begin
            insn_valid <= insn_end;
            if (acc_valid && is_data)
                last_page <= cur_page;
            if (insn_end) begin
                insn_cycles <= sum_sat;
                run_sum     <= '0;
            end else begin
                run_sum <= sum_sat;
            end
        end
    end
endmodule

// File: rtl/pbk_acct_chk.sv
module pbk_acct_chk #(
    parameter int BRK_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic [1:0]       acc_kind,
    input logic             insn_end,
    input logic             insn_valid,
    input logic [BRK_W-1:0] brk_count
);
    // R6
    end_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        insn_end |=> insn_valid);

    // R6
    valid_only_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_end |=> !insn_valid);

    // R7
    brk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (brk_count >= $past(brk_count)) && ((brk_count - $past(brk_count)) <= 1));

    // R7
    brk_hold_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&brk_count) |=> (&brk_count));

    // R8
    brk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(brk_count));

    // R4
    brk_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == 2'b00) |=> $stable(brk_count));
endmodule

bind pbk_acct pbk_acct_chk #(.BRK_W(BRK_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_kind  (acc_kind),
    .insn_end  (insn_end),
    .insn_valid(insn_valid),
    .brk_count (brk_count)
);

// File: tb/pbk_acct_tb.sv
module pbk_acct_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] K_F = 2'b00, K_R = 2'b01, K_W = 2'b10, K_N = 2'b11;

    typedef struct {
        int    exp;
        string tag;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic        insn_end = 1'b0;
    logic [7:0]  insn_cycles;
    logic        insn_valid;
    logic [7:0]  brk_count;

    int       n_chk = 0, n_bad = 0;
    sb_item_t sb[$];
    int       exp_brk = 0;
    bit       have_pg = 0;
    logic [7:0] model_pg = '0;
    bit       done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pbk_acct u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_kind(acc_kind), .insn_end(insn_end), .insn_cycles(insn_cycles),
        .insn_valid(insn_valid), .brk_count(brk_count)
    );

    task automatic chk_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input bit v, input logic [1:0] k, input logic [15:0] a,
                         input bit last, input int exp, input string tag);
        @(negedge clk);
        acc_valid = v; acc_kind = k; acc_addr = a; insn_end = last;
        if (v && (k == K_R || k == K_W)) begin
            if (have_pg && model_pg != a[15:8] && exp_brk < 255) exp_brk++;
            have_pg  = 1;
            model_pg = a[15:8];
        end
        if (last) begin
            have_pg = 0;
            sb.push_back('{exp: exp, tag: tag});
        end
    endtask

    task automatic acc(input logic [1:0] k, input logic [15:0] a);
        drive(1'b1, k, a, 1'b0, 0, "");
    endtask

    task automatic acc_end(input logic [1:0] k, input logic [15:0] a, input int exp, input string tag);
        drive(1'b1, k, a, 1'b1, exp, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        acc_valid = 1'b0; insn_end = 1'b0; acc_kind = K_R; acc_addr = 16'hA5A5;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && insn_valid) begin
            if (sb.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R6: unexpected insn_valid, actual=%0d expected=none", insn_cycles);
            end else begin
                sb_item_t it;
                it = sb.pop_front();
                chk_eq(it.tag, int'(insn_cycles), it.exp);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_eq("R1 valid", int'(insn_valid), 0);
        chk_eq("R1 cycles", int'(insn_cycles), 0);
        chk_eq("R1 brk", int'(brk_count), 0);
        rst_n = 1'b1;
        idle();

        // R9 / R2: swap within one page
        acc(K_F, 16'h8000); acc(K_R, 16'h40F0); acc(K_R, 16'h40F1);
        acc(K_W, 16'h40F1); acc_end(K_W, 16'h40F0, 7, "R9 same page");
        idle(); chk_eq("R3 brk same page", int'(brk_count), 0);

        // R9 / R3: low read, high read, high write, low write across a page
        acc(K_F, 16'h8000); acc(K_R, 16'h40FF); acc(K_R, 16'h4100);
        acc(K_W, 16'h4100); acc_end(K_W, 16'h40FF, 9, "R9 order c");
        idle(); chk_eq("R3 brk after c", int'(brk_count), 2);

        acc(K_F, 16'h8000); acc(K_R, 16'h4100); acc(K_R, 16'h40FF);
        acc(K_W, 16'h4100); acc_end(K_W, 16'h40FF, 10, "R9 order e");
        idle(); chk_eq("R3 brk after e", int'(brk_count), 5);

        acc(K_F, 16'h8000); acc(K_R, 16'h40FF); acc(K_W, 16'h40FF);
        acc(K_R, 16'h4100); acc_end(K_W, 16'h4100, 8, "R9 order a");
        idle(); chk_eq("R3 brk after a", int'(brk_count), 6);

        // R2: lone fetch
        acc_end(K_F, 16'h1000, 3, "R2 fetch only");
        idle();

        // R4: fetches in another page between reads do not break
        acc(K_F, 16'h2000); acc(K_R, 16'h3000); acc(K_F, 16'h5000);
        acc_end(K_R, 16'h3010, 8, "R4 fetch between reads");
        idle(); chk_eq("R4 brk", int'(brk_count), exp_brk);

        // R5: first data access after boundary
        acc_end(K_R, 16'h7000, 1, "R5 prev insn");
        acc(K_F, 16'h0100); acc_end(K_R, 16'h9000, 4, "R5 first data");
        idle(); chk_eq("R5 brk", int'(brk_count), 6);

        // R8: invalid cycle between same-page reads
        acc(K_R, 16'h1100);
        drive(1'b0, K_W, 16'h2200, 1'b0, 0, "");
        acc_end(K_R, 16'h1101, 2, "R8 idle cycle");
        idle(); chk_eq("R8 brk", int'(brk_count), 6);

        // R2: no-op kind costs nothing and leaves the page
        acc(K_R, 16'h1100); acc(K_N, 16'h5500);
        acc_end(K_R, 16'h1100, 2, "R2 no-op kind");
        idle(); chk_eq("R2 no-op brk", int'(brk_count), 6);

        // R6: back-to-back boundaries, and an empty instruction
        acc_end(K_R, 16'h0000, 1, "R6 b2b first");
        acc_end(K_R, 16'h0100, 1, "R6 b2b second");
        drive(1'b0, K_R, 16'h0000, 1'b1, 0, "R6 empty insn");
        idle(); chk_eq("R6 brk", int'(brk_count), 6);

        // R10: total saturation
        for (int i = 0; i < 100; i++) acc(K_F, 16'h0000);
        acc_end(K_F, 16'h0000, 255, "R10 total sat");
        idle();

        // R7: break counter saturation
        for (int i = 0; i < 299; i++) acc(K_R, (i % 2 == 0) ? 16'h0000 : 16'h0100);
        acc_end(K_R, 16'h0100, 255, "R10 total sat breaks");
        idle(); chk_eq("R7 brk sat", int'(brk_count), 255);
        acc(K_R, 16'h0000); acc_end(K_R, 16'h0100, 3, "R7 after sat total");
        idle(); chk_eq("R7 brk held", int'(brk_count), 255);

        repeat (4) idle();
        chk_eq("R6 queue drained", sb.size(), 0);
        finish_run();
    end
endmodule